// File: doc/BRIEF.md
# MII Management Frame Controller

This block drives the two-wire PHY management bus (clause 22 frames on MDC and MDIO) from a single 32-bit command word. A host write places the word in the command register. When the clock divider setting is non-zero, the same write launches a management frame. The block derives MDC from the system clock through a programmable divider. It sends a run of preamble ones and then the 32-bit command, most significant bit first. On a read it releases MDIO at the turnaround and captures sixteen bits from the PHY into the low half of the command register.

Command word layout, bit 31 first on the wire: start delimiter [31:30] (01 for a valid frame), opcode [29:28] (01 = write, 10 = read), PHY address [27:23], register address [22:18], turnaround [17:16], data [15:0]. The divider input is both the rate setting and the enable: zero parks MDC low and blocks new frames. The end of each frame is signalled by a one-cycle completion pulse.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: A frame drives 64 MDIO bit cells: 32 ones of preamble, then command bits 31 down to 0, one bit per MDC period.
- R2: With divider setting N (non-zero), each MDC phase, high or low, lasts exactly 2*N system clocks, so the duty cycle is 50%.
- R3: With the divider at zero, MDC parks low after its current high phase, and a host write updates the register but starts no frame.
- R4: A new divider value takes effect only at an MDC edge: the phase already in progress keeps its old length.
- R5: MDIO output changes only in the system cycle in which MDC falls; read data is sampled when MDC rises.
- R6: For any opcode other than 10 (read), the MDIO output enable stays high for all 64 bit cells of the frame.
- R7: For opcode 10 (read), the output enable is high for bit cells 0 to 45 and low from cell 46 (the turnaround) onward. The 16 bits sampled in cells 48 to 63, first bit most significant, replace command bits [15:0], and bits [31:16] keep their written value.
- R8: `done_irq` pulses for one cycle at the MDC falling edge that ends the frame. In that cycle `busy` and the output enable are already low.
- R9: A host write during a frame replaces the register at once, so later bit cells carry the new contents, and the write does not start a second frame.
- R10: After reset the command register is zero, MDC is low, and `busy`, `done_irq` and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command register |
| wr_data | input | 32 | Command word written by the host |
| clk_div | input | SPD_W | MDC divider setting; zero stops MDC and blocks frames |
| cmd_q | output | 32 | Current command register contents |
| busy | output | 1 | A frame is pending or on the wire |
| done_irq | output | 1 | One-cycle pulse at the end of a frame |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data from the PHY |

## Verification
The hardest situations to reach from the ports are those that depend on where a host action lands relative to MDC. These are a divider change landing inside a phase, a stop request arriving during a low phase, and a host write landing in the middle of a frame. The bench times these stimuli off observed MDC edges and bit-cell counts rather than fixed delays. It changes the divider two cycles after a rising edge, zeroes it while MDC runs, and rewrites the register at bit cell 10. Random read and write frames at divider settings 1 to 4 cover the opcode and data space, with a PHY model answering reads.

// File: rtl/mdio_frame_pkg.sv
// Shared frame geometry for the management frame controller.
// Assumes clause 22 framing: 32-bit preamble followed by a 32-bit command.
package mdio_frame_pkg;
    localparam int          CMD_W    = 32;
    localparam int          PRE_LEN  = 32;
    localparam int          SEQ_LEN  = PRE_LEN + CMD_W;
    localparam int          DATA_W   = 16;
    localparam int          IDX_W    = $clog2(SEQ_LEN);
    localparam int          OP_HI    = 29;
    localparam int          OP_LO    = 28;
    localparam logic [1:0]  OP_READ  = 2'b10;
    localparam int          TA_CELL  = PRE_LEN + (CMD_W - 18);
    localparam int          DAT_CELL = PRE_LEN + (CMD_W - DATA_W);
    typedef logic [CMD_W-1:0]  cmd_t;
    typedef logic [DATA_W-1:0] rdat_t;
endpackage

// File: rtl/mdc_gen.sv
// MDC generator: divides the system clock so that each MDC phase lasts
// 2*clk_div cycles. Emits one-cycle strobes in the cycle MDC toggles.
// Assumes clk_div is a static host setting; a new value is adopted only at
// an MDC edge, and a zero value parks MDC low after its falling edge.
module mdc_gen #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] clk_div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam int HW = SPD_W + 1;

    logic [HW-1:0] half_q;
    logic [HW-1:0] cnt_q;
    logic          mdc_q;
    logic          edge_now;

    assign edge_now  = (half_q != '0) && (cnt_q == half_q - 1'b1);
    assign rise_tick = edge_now & ~mdc_q;
    assign fall_tick = edge_now &  mdc_q;
    assign mdc       = mdc_q;

    // Phase counter: toggles MDC and reloads the phase length on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
            cnt_q  <= '0;
            mdc_q  <= 1'b0;
        end else if (half_q == '0) begin
            cnt_q  <= '0;
            mdc_q  <= 1'b0;
            half_q <= {clk_div, 1'b0};
        end else if (edge_now) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
            if (mdc_q || (clk_div != '0)) begin
                half_q <= {clk_div, 1'b0};
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_seq.sv
// Bit-cell sequencer: walks 64 cells (preamble then command) on MDC falling
// strobes, reading command bits live from the register, and shifts read data
// in on MDC rising strobes. Assumes start is raised only while idle.
module mdio_seq
    import mdio_frame_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  fall_tick,
    input  logic  rise_tick,
    input  cmd_t  frame,
    input  logic  mdio_i,
    output logic  mdio_o,
    output logic  mdio_oe,
    output logic  busy,
    output logic  done,
    output logic  rd_upd,
    output rdat_t rd_data
);
    logic             pend_q;
    logic             act_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] nidx;
    logic             is_rd;

    assign nidx    = idx_q + 1'b1;
    assign is_rd   = (frame[OP_HI:OP_LO] == OP_READ);
    assign busy    = pend_q | act_q;

    // Value driven in a given cell: preamble one, else the command bit.
    function automatic logic cell_bit(input cmd_t f, input logic [IDX_W-1:0] i);
        int pos;
        pos = SEQ_LEN - 1 - int'(i);
        if (int'(i) < PRE_LEN) return 1'b1;
        return f[pos];
    endfunction

    // Cell sequencing, output drive and completion on MDC falling strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            act_q   <= 1'b0;
            idx_q   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rd_upd  <= 1'b0;
        end else begin
            done   <= 1'b0;
            rd_upd <= 1'b0;
            if (start) begin
                pend_q <= 1'b1;
            end
            if (fall_tick) begin
                if (act_q) begin
                    if (int'(idx_q) == SEQ_LEN - 1) begin
                        act_q   <= 1'b0;
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b1;
                        done    <= 1'b1;
                        rd_upd  <= is_rd;
                    end else begin
                        idx_q   <= nidx;
                        mdio_o  <= cell_bit(frame, nidx);
                        mdio_oe <= !(is_rd && (int'(nidx) >= TA_CELL));
                    end
                end else if (pend_q) begin
                    pend_q  <= 1'b0;
                    act_q   <= 1'b1;
                    idx_q   <= '0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b1;
                end
            end
        end
    end

    // Read capture: shift MDIO in on rising strobes during the data cells.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rise_tick && act_q && (int'(idx_q) >= DAT_CELL)) begin
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        end
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
// Management frame controller top: holds the host command register, derives
// MDC and runs one frame per host write while the divider is non-zero.
// Assumes the host does not decode further; every wr_en is a register write.
module mdio_frame_ctrl
    import mdio_frame_pkg::*;
#(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [SPD_W-1:0] clk_div,
    output logic [31:0]      cmd_q,
    output logic             busy,
    output logic             done_irq,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);
    logic  rise_tick;
    logic  fall_tick;
    logic  start;
    logic  rd_upd;
    rdat_t rd_data;
    cmd_t  cmd_r;

    assign start = wr_en && (clk_div != '0) && !busy;
    assign cmd_q = cmd_r;

    mdc_gen #(.SPD_W(SPD_W)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_div   (clk_div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .frame     (cmd_r),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .busy      (busy),
        .done      (done_irq),
        .rd_upd    (rd_upd),
        .rd_data   (rd_data)
    );

    // Command register: host writes win; a finished read refreshes the data field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_r <= '0;
        end else if (wr_en) begin
            cmd_r <= wr_data;
        end else if (rd_upd) begin
            cmd_r[DATA_W-1:0] <= rd_data;
        end
    end
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
// Port-level checker for the management frame controller, bound to the top.
// Tracks MDC phase lengths with its own counter so no long $past is needed.
module mdio_frame_ctrl_chk #(
    parameter int SPD_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SPD_W-1:0] clk_div,
    input logic             busy,
    input logic             done_irq,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);
    logic             mdc_d;
    logic [SPD_W-1:0] div_d;
    logic [SPD_W:0]   half_exp;
    logic [SPD_W+1:0] run;
    logic             chg;

    assign chg = (mdc != mdc_d);

    // Observed phase length versus the divider seen at the previous MDC edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_d    <= 1'b0;
            div_d    <= '0;
            half_exp <= '0;
            run      <= '0;
        end else begin
            mdc_d <= mdc;
            div_d <= clk_div;
            if (chg) begin
                run <= 1;
                if (!mdc || (div_d != '0)) half_exp <= {div_d, 1'b0};
            end else if (run != '1) begin
                run <= run + 1'b1;
            end
        end
    end

    // R2 and R4: every phase lasts 2*N clocks of the divider taken at its opening edge
    a_r4_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && half_exp != '0) |-> (run == {1'b0, half_exp}));

    a_r5_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> ($fell(mdc) && !busy && !mdio_oe));

    a_r3_no_start_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clk_div == '0 && !busy) |=> !busy);

    a_r6_oe_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(.SPD_W(SPD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .clk_div  (clk_div),
    .busy     (busy),
    .done_irq (done_irq),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
);

// File: tb/mdio_frame_ctrl_tb.sv
// Bench: directed corner cases plus seeded random frames against a PHY model.
module mdio_frame_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SPD_W      = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [SPD_W-1:0] clk_div = '0;
    logic [31:0]      cmd_q;
    logic             busy, done_irq, mdc, mdio_o, mdio_oe;
    logic             mdio_i = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ended = 1'b0;

    mdio_frame_ctrl #(.SPD_W(SPD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .clk_div(clk_div), .cmd_q(cmd_q), .busy(busy), .done_irq(done_irq),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        ended = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !ended) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [31:0] w, input int i);
        if (i < 32) return 1'b1;
        return w[63-i];
    endfunction

    function automatic logic exp_oe(input logic [31:0] w, input int i);
        return !((w[29:28] == 2'b10) && (i >= 46));
    endfunction

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One full frame with PHY model; optional rewrite at cell 10 (R9).
    task automatic run_frame(input logic [31:0] w, input logic [SPD_W-1:0] s,
                             input logic [15:0] phy, input bit mid, input logic [31:0] w2);
        logic [63:0] got_b, got_oe, ex_b, ex_oe, mask;
        logic [31:0] wf;
        time t0, t1;
        bit rd;
        @(negedge clk);
        clk_div = s;
        host_write(w);
        wf = w;
        rd = (w[29:28] == 2'b10);
        got_b = '0; got_oe = '0; t0 = 0; t1 = 0;
        @(posedge mdio_oe);
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc);
            if (k == 0) t0 = $time;
            if (k == 1) t1 = $time;
            got_b[63-k]  = mdio_o;
            got_oe[63-k] = mdio_oe;
            if (mid && k == 10) begin
                host_write(w2);
                wf = w2;
            end
            if (rd && k + 1 >= 48 && k + 1 <= 63) begin
                @(negedge mdc);
                mdio_i = phy[63-(k+1)];
            end
        end
        for (int i = 0; i < 64; i++) begin
            ex_b[63-i]  = exp_bit(wf, i);
            ex_oe[63-i] = exp_oe(wf, i);
        end
        mask = ex_oe;
        chk((got_b & mask) == (ex_b & mask), mid ? "R9 bits after rewrite" : "R1 bit cells", got_b & mask, ex_b & mask);
        chk(got_oe == ex_oe, rd ? "R7 read enable" : "R6 write enable", got_oe, ex_oe);
        chk((t1 - t0) == 64'(4 * s * CLK_PERIOD), "R2 MDC period", 64'(t1 - t0), 64'(4 * s * CLK_PERIOD));
        @(negedge mdc);
        @(negedge clk);
        chk(done_irq == 1'b1 && busy == 1'b0 && mdio_oe == 1'b0, "R8 done pulse",
            {61'b0, done_irq, busy, mdio_oe}, 64'b100);
        @(negedge clk);
        chk(done_irq == 1'b0, "R8 done one cycle", {63'b0, done_irq}, 64'b0);
        chk(cmd_q == (rd ? {wf[31:16], phy} : wf), rd ? "R7 data capture" : "R9 register kept",
            {32'b0, cmd_q}, {32'b0, (rd ? {wf[31:16], phy} : wf)});
        mdio_i = 1'b0;
        if (mid) begin
            repeat (8 * s * 4) @(negedge clk);
            chk(busy == 1'b0 && mdio_oe == 1'b0, "R9 no second frame", {62'b0, busy, mdio_oe}, 64'b0);
        end
    endtask

    initial begin
        logic [31:0] r;
        time ta, tb, tc;
        r = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        @(negedge clk);
        // R10: reset state
        chk(cmd_q == 32'b0 && mdc == 1'b0 && busy == 1'b0 && done_irq == 1'b0 && mdio_oe == 1'b0,
            "R10 reset state", {27'b0, cmd_q != 0, mdc, busy, done_irq, mdio_oe}, 64'b0);
        rst_n = 1'b1;

        // Directed: write frame at divider 1, read frame at divider 2
        run_frame({2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'hA5C3}, 6'd1, 16'h0, 1'b0, 32'h0);
        run_frame({2'b01, 2'b10, 5'h03, 5'h1E, 2'b11, 16'hFFFF}, 6'd2, 16'h8001, 1'b0, 32'h0);
        // R9: rewrite at cell 10
        run_frame({2'b01, 2'b01, 5'h00, 5'h01, 2'b10, 16'h0000}, 6'd2, 16'h0, 1'b1,
                  {2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'h3C96});

        // R4: divider change inside a high phase
        @(negedge clk);
        clk_div = 6'd3;
        repeat (40) @(negedge clk);
        @(posedge mdc);
        ta = $time;
        repeat (2) @(negedge clk);
        clk_div = 6'd1;
        @(negedge mdc);
        tb = $time;
        @(posedge mdc);
        tc = $time;
        chk((tb - ta) == 64'(6 * CLK_PERIOD), "R4 old phase kept", 64'(tb - ta), 64'(6 * CLK_PERIOD));
        chk((tc - tb) == 64'(2 * CLK_PERIOD), "R4 new phase", 64'(tc - tb), 64'(2 * CLK_PERIOD));

        // R3: divider zero stops MDC and blocks starts
        @(negedge clk);
        clk_div = 6'd2;
        repeat (20) @(negedge clk);
        clk_div = 6'd0;
        repeat (30) @(negedge clk);
        chk(mdc == 1'b0, "R3 MDC parked", {63'b0, mdc}, 64'b0);
        host_write(32'h6BCD_1234);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0 && mdio_oe == 1'b0 && mdc == 1'b0, "R3 no frame", {61'b0, busy, mdio_oe, mdc}, 64'b0);
        chk(cmd_q == 32'h6BCD_1234, "R3 register written", {32'b0, cmd_q}, {32'b0, 32'h6BCD_1234});
        clk_div = 6'd2;
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R3 no deferred start", {63'b0, busy}, 64'b0);

        // Random frames
        for (int n = 0; n < 10; n++) begin
            logic [31:0] w;
            logic [SPD_W-1:0] s;
            logic [15:0] phy;
            r = $urandom;
            w = {2'b01, (r[0] ? 2'b10 : 2'b01), r[5:1], r[10:6], 2'b10, r[31:16]};
            s = SPD_W'(1 + ($urandom % 4));
            phy = 16'($urandom);
            run_frame(w, s, phy, 1'b0, 32'h0);
        end
        finish_run();
    end
endmodule